// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

The block collects 96 level-sensitive interrupt sources, organised as three banks of 32, and reduces them to two request lines for a processor: a normal request and a fast request. Each source has a mask bit that blocks it from both lines and a select bit that also routes it to the fast line. The block also computes a vector equal to the byte offset (source index times four) of the lowest-numbered source that is both pending and unmasked.

Software reaches the controller over a plain 32-bit register port (byte address, write strobe, write data, read data) inside a 1 KB window. Writes commit on the rising clock edge. Reads are combinational. Each banked group of registers takes three consecutive words, and the bank is picked by address bits [3:2]. A fast-pending group latches fast requests and is cleared by writing ones. The enable, protect and scratch (NMI control) registers only hold their values and gate nothing.

Top module: `vlic_top`

## Requirements
- R1: The pending bit of source n equals the level of `irq_src_i[n]` as sampled at the previous rising clock edge. The pending group reads at 0x010/0x014/0x018 for banks 0/1/2, where bit b of bank k is source 32k+b.
- R2: `irq_o` is high exactly when at least one source is pending and its mask bit (group at 0x050..0x058, 1 = blocked) is clear. Enable bits (group at 0x040..0x048) do not affect it.
- R3: `fiq_o` is high exactly when at least one source is pending, unmasked, and has its select bit (group at 0x030..0x038, 1 = fast) set.
- R4: The vector register at 0x000 reads (32k+b)*4 for the lowest-numbered pending unmasked source, scanning bank 0 first. It reads 0 when no such source exists. Writes to it have no effect.
- R5: Writes to the pending group are ignored. The pending value read back still follows the source levels.
- R6: A fast-pending bit (group at 0x020..0x028) is set one cycle after its source is pending, unmasked and selected. It stays set after the source drops. Writing a word there clears every bit that is 1 in the written data, unless the set condition still holds for that bit.
- R7: The base register at 0x004 stores the written word with bits [1:0] forced to zero.
- R8: Address bits [3:2] select the bank within each group. Word index 3 of any group is unmapped.
- R9: After reset, every register reads zero and both request outputs are low.
- R10: The select, enable and mask groups and the protect (0x008) and NMI-control (0x00C) words read back exactly what was last written.
- R11: A read from an unmapped or misaligned address returns zero. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 96 | Level interrupt sources |
| addr_i | input | 10 | Byte address within the 1 KB window |
| we_i | input | 1 | Write strobe, committed on rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A change on a source line shows up in pending, `irq_o`, `fiq_o` and the vector one clock edge later, because the level is registered once. A fast-pending bit appears one edge after that. A register write changes the outputs and read data right after the edge that commits it. The bench drives every input at the falling edge. It waits for exactly the number of rising edges required, then places an address and samples read data a short delay later, well before the next rising edge. The sweeps cover each of the 96 sources alone, lowest-index priority against the top source, and a moving mask boundary across all banks.

// File: rtl/vlic_pkg.sv
package vlic_pkg;
  parameter int unsigned NUM_BANKS = 3;
  parameter int unsigned BANK_W    = 32;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned ADDR_W    = 10;

  localparam int unsigned NUM_SRC   = NUM_BANKS * BANK_W;
  localparam int unsigned SRC_IDX_W = $clog2(NUM_SRC);
  localparam int unsigned BANK_SEL_W = 2;

  localparam logic [ADDR_W-1:0] OFF_VEC   = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_BASE  = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_PROT  = 10'h008;
  localparam logic [ADDR_W-1:0] OFF_NMI   = 10'h00C;
  localparam logic [ADDR_W-1:0] OFF_PEND  = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_FPEND = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_SEL   = 10'h030;
  localparam logic [ADDR_W-1:0] OFF_EN    = 10'h040;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 10'h050;

  typedef struct packed {
    logic vec;
    logic base;
    logic prot;
    logic nmi;
    logic pend;
    logic fpend;
    logic sel;
    logic en;
    logic mask;
    logic [BANK_SEL_W-1:0] bank;
  } dec_t;
endpackage

// File: rtl/vlic_decode.sv
module vlic_decode
  import vlic_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic                  aligned;
  logic [ADDR_W-1:0]     grp_base;
  logic [BANK_SEL_W-1:0] word;
  logic                  bank_ok;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign grp_base = {addr_i[ADDR_W-1:4], 4'h0};
  assign word     = addr_i[3:2];
  assign bank_ok  = aligned && (32'(word) < NUM_BANKS);

  always_comb begin
    dec_o       = '0;
    dec_o.bank  = word;
    dec_o.vec   = aligned && (addr_i == OFF_VEC);
    dec_o.base  = aligned && (addr_i == OFF_BASE);
    dec_o.prot  = aligned && (addr_i == OFF_PROT);
    dec_o.nmi   = aligned && (addr_i == OFF_NMI);
    dec_o.pend  = bank_ok && (grp_base == OFF_PEND);
    dec_o.fpend = bank_ok && (grp_base == OFF_FPEND);
    dec_o.sel   = bank_ok && (grp_base == OFF_SEL);
    dec_o.en    = bank_ok && (grp_base == OFF_EN);
    dec_o.mask  = bank_ok && (grp_base == OFF_MASK);
  end
endmodule

// File: rtl/vlic_bank.sv
module vlic_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] wdata_i,
  input  logic         we_sel_i,
  input  logic         we_en_i,
  input  logic         we_mask_i,
  input  logic         we_fclr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] fpend_o,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] act_o,
  output logic [W-1:0] fact_o
);
  logic [W-1:0] clr;

  assign act_o  = pend_o & ~mask_o;
  assign fact_o = act_o & sel_o;
  assign clr    = we_fclr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= '0;
      fpend_o <= '0;
      sel_o   <= '0;
      en_o    <= '0;
      mask_o  <= '0;
    end else begin
      pend_o  <= src_i;
      // set wins over clear while the source is still active
      fpend_o <= (fpend_o & ~clr) | fact_o;
      if (we_sel_i)  sel_o  <= wdata_i;
      if (we_en_i)   en_o   <= wdata_i;
      if (we_mask_i) mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/vlic_vec_enc.sv
module vlic_vec_enc
  import vlic_pkg::*;
(
  input  logic [NUM_SRC-1:0] act_i,
  output logic [DATA_W-1:0]  vec_o
);
  logic [SRC_IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) idx = SRC_IDX_W'(i);
    end
    vec_o = DATA_W'(idx) << 2;
  end
endmodule

// File: rtl/vlic_top.sv
module vlic_top
  import vlic_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   irq_src_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  dec_t dec;

  logic [BANK_W-1:0] pend_w  [NUM_BANKS];
  logic [BANK_W-1:0] fpend_w [NUM_BANKS];
  logic [BANK_W-1:0] sel_w   [NUM_BANKS];
  logic [BANK_W-1:0] en_w    [NUM_BANKS];
  logic [BANK_W-1:0] mask_w  [NUM_BANKS];

  logic [NUM_SRC-1:0] pend_flat, fpend_flat, sel_flat, mask_flat, act_flat, fact_flat;
  logic [DATA_W-1:0]  vec, base_q, prot_q, nmi_q;

  vlic_decode u_dec (.addr_i(addr_i), .dec_o(dec));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = we_i && (32'(dec.bank) == b);

    vlic_bank #(.W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (irq_src_i[b*BANK_W +: BANK_W]),
      .wdata_i   (wdata_i),
      .we_sel_i  (hit && dec.sel),
      .we_en_i   (hit && dec.en),
      .we_mask_i (hit && dec.mask),
      .we_fclr_i (hit && dec.fpend),
      .pend_o    (pend_w[b]),
      .fpend_o   (fpend_w[b]),
      .sel_o     (sel_w[b]),
      .en_o      (en_w[b]),
      .mask_o    (mask_w[b]),
      .act_o     (act_flat[b*BANK_W +: BANK_W]),
      .fact_o    (fact_flat[b*BANK_W +: BANK_W])
    );

    assign pend_flat[b*BANK_W +: BANK_W]  = pend_w[b];
    assign fpend_flat[b*BANK_W +: BANK_W] = fpend_w[b];
    assign sel_flat[b*BANK_W +: BANK_W]   = sel_w[b];
    assign mask_flat[b*BANK_W +: BANK_W]  = mask_w[b];
  end

  vlic_vec_enc u_enc (.act_i(act_flat), .vec_o(vec));

  assign irq_o = |act_flat;
  assign fiq_o = |fact_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (we_i) begin
      if (dec.base) base_q <= wdata_i & ~DATA_W'(3);
      if (dec.prot) prot_q <= wdata_i;
      if (dec.nmi)  nmi_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dec.vec)  rdata_o = vec;
    if (dec.base) rdata_o = base_q;
    if (dec.prot) rdata_o = prot_q;
    if (dec.nmi)  rdata_o = nmi_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(dec.bank) == b) begin
        if (dec.pend)  rdata_o = pend_w[b];
        if (dec.fpend) rdata_o = fpend_w[b];
        if (dec.sel)   rdata_o = sel_w[b];
        if (dec.en)    rdata_o = en_w[b];
        if (dec.mask)  rdata_o = mask_w[b];
      end
    end
  end
endmodule

// File: rtl/vlic_chk.sv
module vlic_chk
  import vlic_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] fpend_i,
  input logic [NUM_SRC-1:0] sel_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic [DATA_W-1:0]  vec_i,
  input logic [DATA_W-1:0]  base_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               irq_i,
  input logic               fiq_i
);
  AST_PEND_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (pend_i == $past(src_i))); // R1

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~mask_i) == '0) |-> (!irq_i && !fiq_i)); // R2

  AST_FIQ_NEEDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_i |-> irq_i); // R3

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> (vec_i == '0)); // R4

  AST_FPEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((fpend_i & ~$past(fpend_i) & ~$past(pend_i & sel_i & ~mask_i)) == '0)); // R6

  AST_BASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i) && $past(addr_i) == OFF_BASE)
      |-> (base_i == ($past(wdata_i) & ~DATA_W'(3)))); // R7
endmodule

bind vlic_top vlic_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (irq_src_i),
  .pend_i  (pend_flat),
  .fpend_i (fpend_flat),
  .sel_i   (sel_flat),
  .mask_i  (mask_flat),
  .vec_i   (vec),
  .base_i  (base_q),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .irq_i   (irq_o),
  .fiq_i   (fiq_o)
);

// File: tb/vlic_top_tb.sv
module vlic_top_tb;
  import vlic_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] src = '0;
  logic [ADDR_W-1:0]  addr = '0;
  logic               we = 1'b0;
  logic [DATA_W-1:0]  wdata = '0;
  logic [DATA_W-1:0]  rdata;
  logic               irq, fiq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  vlic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_src(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] grp, input int b);
    return grp + ADDR_W'(4 * b);
  endfunction

  function automatic logic [DATA_W-1:0] mask_below(input int m, input int b);
    int lo = m - b * BANK_W;
    if (lo <= 0) return '0;
    if (lo >= BANK_W) return '1;
    return (DATA_W'(1) << lo) - 1;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [DATA_W-1:0] d;
    logic [ADDR_W-1:0] grps [5];
    grps[0] = OFF_PEND; grps[1] = OFF_FPEND; grps[2] = OFF_SEL; grps[3] = OFF_EN; grps[4] = OFF_MASK;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 irq", 32'(irq), 0);
    chk("R9 fiq", 32'(fiq), 0);
    rd(OFF_VEC, d);  chk("R9 vec", d, 0);
    rd(OFF_BASE, d); chk("R9 base", d, 0);
    rd(OFF_PROT, d); chk("R9 prot", d, 0);
    rd(OFF_NMI, d);  chk("R9 nmi", d, 0);
    for (int g = 0; g < 5; g++)
      for (int b = 0; b < NUM_BANKS; b++) begin
        rd(bank_addr(grps[g], b), d); chk("R9 group", d, 0);
      end

    // R1 R2 R4: each source alone
    for (int i = 0; i < NUM_SRC; i++) begin
      set_src(NUM_SRC'(1) << i);
      rd(bank_addr(OFF_PEND, i / BANK_W), d);
      chk("R1 pend", d, DATA_W'(1) << (i % BANK_W));
      chk("R2 irq single", 32'(irq), 1);
      chk("R3 fiq unselected", 32'(fiq), 0);
      rd(OFF_VEC, d); chk("R4 vec single", d, DATA_W'(i * 4));
    end

    // R4 lowest index wins against the top source
    for (int i = 0; i < NUM_SRC - 1; i += 5) begin
      set_src((NUM_SRC'(1) << i) | (NUM_SRC'(1) << (NUM_SRC - 1)));
      rd(OFF_VEC, d); chk("R4 vec priority", d, DATA_W'(i * 4));
    end

    // R2 R4 moving mask boundary with all sources high
    set_src('1);
    for (int m = 0; m <= NUM_SRC; m += 3) begin
      for (int b = 0; b < NUM_BANKS; b++) wr(bank_addr(OFF_MASK, b), mask_below(m, b));
      rd(OFF_VEC, d);
      chk("R4 vec masked", d, (m < NUM_SRC) ? DATA_W'(m * 4) : '0);
      chk("R2 irq masked", 32'(irq), (m < NUM_SRC) ? 1 : 0);
    end
    for (int b = 0; b < NUM_BANKS; b++) wr(bank_addr(OFF_MASK, b), '0);

    // R2 enable bits do not gate; R10 readback
    for (int b = 0; b < NUM_BANKS; b++) begin
      wr(bank_addr(OFF_EN, b), 32'hA5A5_0000 + 32'(b));
      rd(bank_addr(OFF_EN, b), d); chk("R10 en readback", d, 32'hA5A5_0000 + 32'(b));
    end
    set_src(NUM_SRC'(1) << 40);
    chk("R2 irq enable ignored", 32'(irq), 1);
    for (int b = 0; b < NUM_BANKS; b++) wr(bank_addr(OFF_EN, b), '0);
    chk("R2 irq enable zero", 32'(irq), 1);

    // R3 fast routing per source
    for (int i = 0; i < NUM_SRC; i += 7) begin
      set_src(NUM_SRC'(1) << i);
      wr(bank_addr(OFF_SEL, i / BANK_W), DATA_W'(1) << (i % BANK_W));
      chk("R3 fiq selected", 32'(fiq), 1);
      wr(bank_addr(OFF_MASK, i / BANK_W), DATA_W'(1) << (i % BANK_W));
      chk("R3 fiq masked", 32'(fiq), 0);
      chk("R2 irq masked single", 32'(irq), 0);
      wr(bank_addr(OFF_MASK, i / BANK_W), '0);
      wr(bank_addr(OFF_SEL, i / BANK_W), '0);
    end

    // R6 fast-pending capture and write-one-to-clear
    set_src('0);
    for (int b = 0; b < NUM_BANKS; b++) wr(bank_addr(OFF_FPEND, b), '1);
    for (int b = 0; b < NUM_BANKS; b++) begin
      rd(bank_addr(OFF_FPEND, b), d); chk("R6 fpend cleared", d, 0);
    end
    wr(bank_addr(OFF_SEL, 1), 32'h0000_0030);
    set_src(NUM_SRC'(32'h0000_0030) << 32);
    @(negedge clk);
    rd(bank_addr(OFF_FPEND, 1), d); chk("R6 fpend set", d, 32'h0000_0030);
    wr(bank_addr(OFF_FPEND, 1), 32'h0000_0010);
    rd(bank_addr(OFF_FPEND, 1), d); chk("R6 set wins", d, 32'h0000_0030);
    set_src('0);
    @(negedge clk);
    rd(bank_addr(OFF_FPEND, 1), d); chk("R6 sticky", d, 32'h0000_0030);
    wr(bank_addr(OFF_FPEND, 1), 32'h0000_0010);
    rd(bank_addr(OFF_FPEND, 1), d); chk("R6 w1c partial", d, 32'h0000_0020);
    wr(bank_addr(OFF_FPEND, 1), 32'h0000_0020);
    rd(bank_addr(OFF_FPEND, 1), d); chk("R6 w1c rest", d, 0);
    wr(bank_addr(OFF_SEL, 1), '0);

    // R5 pending writes ignored
    set_src(NUM_SRC'(32'h1234_5678));
    wr(bank_addr(OFF_PEND, 0), '0);
    rd(bank_addr(OFF_PEND, 0), d); chk("R5 pend write zero", d, 32'h1234_5678);
    set_src('0);
    wr(bank_addr(OFF_PEND, 2), '1);
    rd(bank_addr(OFF_PEND, 2), d); chk("R5 pend write ones", d, 0);
    chk("R5 irq after write", 32'(irq), 0);

    // R4 vector write has no effect
    wr(OFF_VEC, 32'h0000_0100);
    rd(OFF_VEC, d); chk("R4 vec write ignored", d, 0);

    // R7 base alignment, R10 scalar readback
    wr(OFF_BASE, 32'hFFFF_FFFF);
    rd(OFF_BASE, d); chk("R7 base ones", d, 32'hFFFF_FFFC);
    wr(OFF_BASE, 32'h8000_0007);
    rd(OFF_BASE, d); chk("R7 base odd", d, 32'h8000_0004);
    wr(OFF_PROT, 32'hDEAD_BEEF);
    rd(OFF_PROT, d); chk("R10 prot", d, 32'hDEAD_BEEF);
    wr(OFF_NMI, 32'h0000_0003);
    rd(OFF_NMI, d); chk("R10 nmi", d, 32'h0000_0003);

    // R8 bank selection by address bits [3:2]
    for (int b = 0; b < NUM_BANKS; b++) wr(bank_addr(OFF_SEL, b), 32'h1111_1111 * 32'(b + 1));
    for (int b = 0; b < NUM_BANKS; b++) begin
      rd(bank_addr(OFF_SEL, b), d); chk("R8 bank sel", d, 32'h1111_1111 * 32'(b + 1));
    end
    rd(bank_addr(OFF_SEL, 3), d); chk("R8 word 3 unmapped", d, 0);
    wr(bank_addr(OFF_SEL, 3), 32'hFFFF_FFFF);
    for (int b = 0; b < NUM_BANKS; b++) begin
      rd(bank_addr(OFF_SEL, b), d); chk("R8 word 3 write", d, 32'h1111_1111 * 32'(b + 1));
    end

    // R11 unmapped and misaligned
    rd(10'h200, d); chk("R11 read far", d, 0);
    rd(10'h3FC, d); chk("R11 read top", d, 0);
    rd(OFF_PROT + 10'h1, d); chk("R11 read misaligned", d, 0);
    wr(10'h060, 32'h5555_5555);
    wr(OFF_PROT + 10'h2, 32'h0);
    wr(OFF_BASE + 10'h1, 32'h0);
    rd(OFF_PROT, d); chk("R11 prot kept", d, 32'hDEAD_BEEF);
    rd(OFF_BASE, d); chk("R11 base kept", d, 32'h8000_0004);
    rd(bank_addr(OFF_MASK, 0), d); chk("R11 mask kept", d, 0);
    chk("R11 irq quiet", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule